// File: doc/BRIEF.md
# OSD Serial RAM Write Decoder

This block sits between a serial slave link (active-low select, shift clock, data in) and the write port of an on-screen-display memory of 11 rows by 32 columns. It assembles incoming bits into bytes and decides from each byte's header bits and from its own format state whether the byte is a row address, a column address or a display value. Display values are written to the memory at the current row and column pointer.

Three packet styles are decoded. In the first, every value is preceded by its own row and column. In the second, one row is followed by repeated column/value pairs. In the third, a single row and column are followed by an unbounded run of values, each written one column further on. That run ends only when select is released. The serial inputs are brought into the system clock domain by synchronizers, and the shift clock is edge-detected there.

FSM states:
- `ST_WAIT_ROW` is entered at frame start and whenever select is high.
- `ST_WAIT_COL` follows a row address.
- `ST_WAIT_INFO` follows a column whose streaming bit is clear.
- `ST_WAIT_ADDR` follows a written value in the first two styles.
- `ST_STREAM` is the run mode.

FSM transitions:
- A row byte moves `ST_WAIT_ROW` or `ST_WAIT_ADDR` to `ST_WAIT_COL`.
- A row byte in `ST_WAIT_COL` reloads the row and keeps the state.
- A column byte moves `ST_WAIT_COL` or `ST_WAIT_ADDR` to `ST_STREAM` when its streaming bit is set, and to `ST_WAIT_INFO` when that bit is clear.
- Any byte moves `ST_WAIT_INFO` to `ST_WAIT_ADDR`.
- `ST_STREAM` loops on itself.
- Select high returns every state to `ST_WAIT_ROW`.

Top module: `osd_ram_loader`

## Requirements
- R1: While `ss_n` is low, bits are taken from `mosi` on each rising edge of `sck`, most significant bit first. Eight bits form one byte, and a frame may carry any number of bytes.
- R2: A byte that arrives while an address is expected is a row address when bit 7 is 1. The row number is taken from bits 3:0.
- R3: After a row, a byte with bit 7 = 0 is a column address taken from bits 4:0. If its bit 6 is 0, the next byte is written at (row, column).
- R4: After a value has been written in the non-streaming styles, a byte with bit 7 = 0 is a new column on the same row. A byte with bit 7 = 1 is a new row that must then be followed by a column.
- R5: A column address with bit 6 = 1 starts streaming. Every following byte is written, the first at the given column and each later one at the next column.
- R6: Once streaming has started, every byte is data, whatever its bit 7 and bit 6, until `ss_n` goes high.
- R7: While streaming, the column wraps from 31 to 0 and the row increases by one. After row 10, column 31 has been written, no further writes happen in that frame.
- R8: A row number above 10 produces no write for any value sent to it.
- R9: When `ss_n` goes high, the bit count is cleared and a partial byte is discarded. The next frame starts by expecting a row address.
- R10: At frame start, a byte with bit 7 = 0 is discarded and produces no write.
- R11: After reset, `wr_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ss_n | input | 1 | Serial select, active low, asynchronous to `clk` |
| sck | input | 1 | Serial shift clock, sampled on its rising edge |
| mosi | input | 1 | Serial data in, MSB first |
| wr_en | output | 1 | One-cycle memory write strobe |
| wr_row | output | 4 | Memory row for the write |
| wr_col | output | 5 | Memory column for the write |
| wr_data | output | 8 | Byte to be written |

## Verification
A wrong format state appears at the memory port within one byte. A value can land at a stale row or column. An address byte can be written as data, or a data byte can be swallowed as an address. Each of these is visible as a wrong cell or a wrong write count once the frame closes. A pointer fault in streaming shows up on the first write after a column wrap or at the end of row 10. A missed select reset shows up on the first byte of the next frame.

// File: rtl/osd_pkg.sv
package osd_pkg;
    typedef enum logic [2:0] {
        ST_WAIT_ROW,
        ST_WAIT_COL,
        ST_WAIT_INFO,
        ST_WAIT_ADDR,
        ST_STREAM
    } fsm_state_t;
endpackage

// File: rtl/osd_byte_rx.sv
module osd_byte_rx #(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ss_n,
    input  logic              sck,
    input  logic              mosi,
    output logic              frame_act,
    output logic              byte_vld,
    output logic [DATA_W-1:0] rx_byte
);
    localparam int CNT_W = $clog2(DATA_W);

    logic [SYNC_STAGES-1:0] ss_q, sck_q, mosi_q;
    logic                   sck_d;
    logic [CNT_W-1:0]       bit_cnt;
    logic [DATA_W-1:0]      shreg;
    logic                   sck_rise;

    assign frame_act = !ss_q[SYNC_STAGES-1];
    assign sck_rise  = sck_q[SYNC_STAGES-1] && !sck_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ss_q   <= '1;
            sck_q  <= '0;
            mosi_q <= '0;
            sck_d  <= 1'b0;
        end else begin
            ss_q   <= {ss_q[SYNC_STAGES-2:0], ss_n};
            sck_q  <= {sck_q[SYNC_STAGES-2:0], sck};
            mosi_q <= {mosi_q[SYNC_STAGES-2:0], mosi};
            sck_d  <= sck_q[SYNC_STAGES-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt  <= '0;
            shreg    <= '0;
            byte_vld <= 1'b0;
            rx_byte  <= '0;
        end else begin
            byte_vld <= 1'b0;
            if (!frame_act) begin
                bit_cnt <= '0;
            end else if (sck_rise) begin
                shreg   <= {shreg[DATA_W-2:0], mosi_q[SYNC_STAGES-1]};
                bit_cnt <= bit_cnt + 1'b1;
                if (bit_cnt == CNT_W'(DATA_W - 1)) begin
                    byte_vld <= 1'b1;
                    rx_byte  <= {shreg[DATA_W-2:0], mosi_q[SYNC_STAGES-1]};
                    bit_cnt  <= '0;
                end
            end
        end
    end
endmodule

// File: rtl/osd_wr_ptr.sv
module osd_wr_ptr #(
    parameter int ROW_W    = 4,
    parameter int COL_W    = 5,
    parameter int LAST_ROW = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_row,
    input  logic             load_col,
    input  logic             step,
    input  logic [ROW_W-1:0] row_in,
    input  logic [COL_W-1:0] col_in,
    output logic [ROW_W-1:0] row,
    output logic [COL_W-1:0] col,
    output logic             in_range
);
    assign in_range = (row <= ROW_W'(LAST_ROW));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            row <= '0;
            col <= '0;
        end else begin
            if (load_row) row <= row_in;
            if (load_col) col <= col_in;
            if (step && in_range) begin
                if (col == '1) begin
                    col <= '0;
                    row <= row + 1'b1;
                end else begin
                    col <= col + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/osd_ram_loader.sv
module osd_ram_loader
    import osd_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int ROW_W    = 4,
    parameter int COL_W    = 5,
    parameter int LAST_ROW = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ss_n,
    input  logic              sck,
    input  logic              mosi,
    output logic              wr_en,
    output logic [ROW_W-1:0]  wr_row,
    output logic [COL_W-1:0]  wr_col,
    output logic [DATA_W-1:0] wr_data
);
    localparam int ROW_FLAG = DATA_W - 1;
    localparam int RUN_FLAG = DATA_W - 2;

    logic              frame_act, byte_vld;
    logic [DATA_W-1:0] rx_byte;
    logic [ROW_W-1:0]  cur_row;
    logic [COL_W-1:0]  cur_col;
    logic              in_range;
    logic              ld_row, ld_col, wr_go, step;
    logic              is_row, is_run;
    fsm_state_t        state, nxt;

    assign is_row = rx_byte[ROW_FLAG];
    assign is_run = rx_byte[RUN_FLAG];

    osd_byte_rx #(.DATA_W(DATA_W), .SYNC_STAGES(2)) u_rx (
        .clk(clk), .rst_n(rst_n), .ss_n(ss_n), .sck(sck), .mosi(mosi),
        .frame_act(frame_act), .byte_vld(byte_vld), .rx_byte(rx_byte)
    );

    osd_wr_ptr #(.ROW_W(ROW_W), .COL_W(COL_W), .LAST_ROW(LAST_ROW)) u_ptr (
        .clk(clk), .rst_n(rst_n),
        .load_row(ld_row), .load_col(ld_col), .step(step),
        .row_in(rx_byte[ROW_W-1:0]), .col_in(rx_byte[COL_W-1:0]),
        .row(cur_row), .col(cur_col), .in_range(in_range)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_WAIT_ROW;
        else        state <= nxt;
    end

    always_comb begin
        nxt    = state;
        ld_row = 1'b0;
        ld_col = 1'b0;
        wr_go  = 1'b0;
        step   = 1'b0;
        if (!frame_act) begin
            nxt = ST_WAIT_ROW;
        end else if (byte_vld) begin
            unique case (state)
                ST_WAIT_ROW: begin
                    if (is_row) begin
                        ld_row = 1'b1;
                        nxt    = ST_WAIT_COL;
                    end
                end
                ST_WAIT_COL, ST_WAIT_ADDR: begin
                    if (is_row) begin
                        ld_row = 1'b1;
                        nxt    = ST_WAIT_COL;
                    end else begin
                        ld_col = 1'b1;
                        nxt    = is_run ? ST_STREAM : ST_WAIT_INFO;
                    end
                end
                ST_WAIT_INFO: begin
                    wr_go = 1'b1;
                    nxt   = ST_WAIT_ADDR;
                end
                ST_STREAM: begin
                    wr_go = 1'b1;
                    step  = 1'b1;
                end
                default: nxt = ST_WAIT_ROW;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_en   <= 1'b0;
            wr_row  <= '0;
            wr_col  <= '0;
            wr_data <= '0;
        end else begin
            wr_en <= wr_go && in_range;
            if (wr_go) begin
                wr_row  <= cur_row;
                wr_col  <= cur_col;
                wr_data <= rx_byte;
            end
        end
    end
endmodule

// File: rtl/osd_ram_loader_chk.sv
module osd_ram_loader_chk
    import osd_pkg::*;
#(
    parameter int ROW_W    = 4,
    parameter int LAST_ROW = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [ROW_W-1:0] wr_row,
    input logic             frame_act,
    input logic             byte_vld,
    input fsm_state_t       state
);
    AST_WRITE_ROW_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_row <= ROW_W'(LAST_ROW))); // R8

    AST_SELECT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_act |=> (state == ST_WAIT_ROW)); // R9

    AST_STREAM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STREAM && frame_act) |=> (state == ST_STREAM)); // R6

    AST_WRITE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en); // R1

    AST_BYTE_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        byte_vld |-> $past(frame_act)); // R1
endmodule

bind osd_ram_loader osd_ram_loader_chk #(.ROW_W(ROW_W), .LAST_ROW(LAST_ROW)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_row(wr_row),
    .frame_act(frame_act), .byte_vld(byte_vld), .state(state)
);

// File: tb/osd_ram_loader_test.sv
`timescale 1ns/1ps
module osd_ram_loader_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ss_n = 1'b1;
    logic       sck = 1'b0;
    logic       mosi = 1'b0;
    logic       wr_en;
    logic [3:0] wr_row;
    logic [4:0] wr_col;
    logic [7:0] wr_data;

    int checks = 0;
    int errors = 0;
    int writes = 0;
    bit done = 1'b0;
    logic [7:0] mem [0:15][0:31];

    always #10 clk = ~clk;

    osd_ram_loader uut (
        .clk(clk), .rst_n(rst_n), .ss_n(ss_n), .sck(sck), .mosi(mosi),
        .wr_en(wr_en), .wr_row(wr_row), .wr_col(wr_col), .wr_data(wr_data)
    );

    always @(posedge clk) begin
        if (rst_n && wr_en) begin
            mem[wr_row][wr_col] <= wr_data;
            writes <= writes + 1;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic clear_shadow();
        @(negedge clk);
        for (int r = 0; r < 16; r++)
            for (int c = 0; c < 32; c++)
                mem[r][c] = 8'hEE;
        writes = 0;
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bits(input logic [7:0] b, input int nbits);
        for (int i = 7; i > 7 - nbits; i--) begin
            mosi = b[i];
            wait_clk(4);
            sck = 1'b1;
            wait_clk(4);
            sck = 1'b0;
        end
    endtask

    task automatic send_byte(input logic [7:0] b);
        send_bits(b, 8);
    endtask

    task automatic frame_open();
        wait_clk(2);
        ss_n = 1'b0;
        wait_clk(6);
    endtask

    task automatic frame_close();
        wait_clk(8);
        ss_n = 1'b1;
        wait_clk(8);
    endtask

    task automatic test_format_a();
        clear_shadow();
        frame_open();
        send_byte(8'h82); send_byte(8'h05); send_byte(8'h41);
        send_byte(8'h83); send_byte(8'h07); send_byte(8'h42);
        frame_close();
        check("R2/R3 row2 col5", mem[2][5], 8'h41);
        check("R4 new row3 col7", mem[3][7], 8'h42);
        check("R3 write count", writes, 2);
    endtask

    task automatic test_format_b();
        clear_shadow();
        frame_open();
        send_byte(8'h81); send_byte(8'h02); send_byte(8'h11);
        send_byte(8'h03); send_byte(8'h12);
        send_byte(8'h1E); send_byte(8'h13);
        frame_close();
        check("R4 row1 col2", mem[1][2], 8'h11);
        check("R4 row1 col3", mem[1][3], 8'h12);
        check("R4 row1 col30", mem[1][30], 8'h13);
        check("R4 write count", writes, 3);
    endtask

    task automatic test_stream_wrap();
        clear_shadow();
        frame_open();
        send_byte(8'h84); send_byte(8'h5E);
        send_byte(8'hA1); send_byte(8'hA2); send_byte(8'hF3); send_byte(8'h94);
        frame_close();
        check("R5 stream first col30", mem[4][30], 8'hA1);
        check("R5 stream col31", mem[4][31], 8'hA2);
        check("R7 wrap to row5 col0", mem[5][0], 8'hF3);
        check("R6 row-like byte is data", mem[5][1], 8'h94);
        check("R6 stream write count", writes, 4);
    endtask

    task automatic test_stream_end();
        clear_shadow();
        frame_open();
        send_byte(8'h8A); send_byte(8'h5E);
        send_byte(8'h01); send_byte(8'h02); send_byte(8'h03); send_byte(8'h04);
        frame_close();
        check("R7 row10 col30", mem[10][30], 8'h01);
        check("R7 row10 col31", mem[10][31], 8'h02);
        check("R7 stop past end", writes, 2);
        check("R7 no write row11", mem[11][0], 8'hEE);
    endtask

    task automatic test_bad_row();
        clear_shadow();
        frame_open();
        send_byte(8'h8C); send_byte(8'h03); send_byte(8'h55);
        wait_clk(4);
        check("R8 row12 no write", writes, 0);
        send_byte(8'h86); send_byte(8'h04); send_byte(8'h66);
        frame_close();
        check("R8 legal row after", mem[6][4], 8'h66);
        check("R8 write count", writes, 1);
    endtask

    task automatic test_start_discard();
        clear_shadow();
        frame_open();
        send_byte(8'h33);
        wait_clk(4);
        check("R10 leading byte discarded", writes, 0);
        send_byte(8'h87); send_byte(8'h01); send_byte(8'h77);
        frame_close();
        check("R10 row7 col1", mem[7][1], 8'h77);
        check("R10 write count", writes, 1);
    endtask

    task automatic test_select_reset();
        clear_shadow();
        frame_open();
        send_byte(8'h84); send_byte(8'h44); send_byte(8'h10);
        frame_close();
        frame_open();
        send_byte(8'h88); send_byte(8'h02); send_byte(8'h21);
        frame_close();
        check("R9 stream before release", mem[4][4], 8'h10);
        check("R9 row byte after release", mem[8][2], 8'h21);
        check("R9 write count", writes, 2);
        clear_shadow();
        frame_open();
        send_bits(8'hF0, 4);
        frame_close();
        frame_open();
        send_byte(8'h89); send_byte(8'h00); send_byte(8'h5A);
        frame_close();
        check("R9 partial byte dropped", mem[9][0], 8'h5A);
        check("R1 write count after partial", writes, 1);
    endtask

    initial begin
        wait_clk(5);
        check("R11 wr_en low in reset", wr_en, 0);
        rst_n = 1'b1;
        wait_clk(5);
        check("R11 wr_en low after reset", wr_en, 0);
        test_format_a();
        test_format_b();
        test_stream_wrap();
        test_stream_end();
        test_bad_row();
        test_start_discard();
        test_select_reset();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule